// File: doc/BRIEF.md
# Synthesizer Power Control Sequencer

This block decides whether a frequency synthesizer loop is powered and then drives what follows from that decision. A chip-enable pin and a power-down bit written over a three-wire serial port are combined into one power request. While the request is off, the prescaler is unbiased and the charge pump and phase detector stop driving. Both the reference divider and the feedback divider are held at zero. A separate keep-alive bit keeps the reference input buffer enabled even when the pin or the power-down bit has shut the loop down.

Power-up goes through one wake cycle. In that cycle the prescaler and the reference buffer are enabled, but the counters are still held. Both dividers are then released on the same clock edge, so their first terminal counts stay in a fixed relation whatever they held before the shutdown. The serial port keeps accepting frames in every power state. A small reference divider and a small feedback divider are included so that the restart alignment can be observed at the terminal-count outputs.

Top module: `pll_power_sequencer`

## Requirements
- R1: The loop is requested on only when `chip_en_i` is high and the power-down bit is clear. One clock edge after the request goes away, `loop_drive_en_o` and `presc_en_o` are low, whatever the power-down bit holds.
- R2: The keep-alive bit (bit 1 of a power word, address 0) holds `ref_buf_en_o` high whatever the state of the pin and the power-down bit. When the keep-alive bit is clear, `ref_buf_en_o` is low whenever the loop is off.
- R3: While the loop is off, `loop_drive_en_o` and `presc_en_o` are low, and `r_tc_o` and `n_tc_o` never pulse.
- R4: Both counters are cleared while not running. With ticks on every cycle and divide value D, the first terminal pulse comes D clock edges after release. That is D+1 edges after the request rises.
- R5: After the request rises, the first edge sets `presc_en_o` with `loop_drive_en_o` still low, and the second edge sets `loop_drive_en_o`.
- R6: With equal R and N divide values and ticks on every cycle, the terminal pulses of the two dividers coincide after every power-up, including a power-up that follows a shutdown in mid-count.
- R7: A serial frame of 24 bits is shifted in MSB first on rising `ser_clk_i`. The frame is data[21:0] followed by address[1:0]. A rising `ser_le_i` loads the addressed register. Address 0 is the power word (bit 0 = power-down, bit 1 = keep-alive), address 1 is the R divide value and address 2 is the N divide value. Loading works while the loop is off.
- R8: A frame with address 3 changes nothing: the power state and the divider periods stay as they were.
- R9: A divide value of 0 acts as 1, so the terminal output pulses on every tick.
- R10: After reset, all enable and terminal outputs are low, the power-down and keep-alive bits are clear, and both divide values are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en_i | input | 1 | Chip-enable pin; low forces the loop off |
| ser_clk_i | input | 1 | Serial shift clock, sampled in the `clk` domain |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe; its rising edge writes the addressed register |
| ref_tick_i | input | 1 | Reference divider count enable |
| vco_tick_i | input | 1 | Feedback divider count enable (prescaler output) |
| presc_en_o | output | 1 | Prescaler bias enable |
| loop_drive_en_o | output | 1 | Output enable of charge pump and phase detector |
| ref_buf_en_o | output | 1 | Reference input buffer enable |
| r_tc_o | output | 1 | Reference divider terminal count pulse |
| n_tc_o | output | 1 | Feedback divider terminal count pulse |

## Verification
The power decision is tried with the pin alone, with the software bit alone, with both, and with the keep-alive bit set against each of them. This separates plain gating from priority and from the exemption. Restart alignment is tried after a power-up from reset and again after a shutdown in mid-count with equal divide values. Different R and N values show that the edge counts follow each divide value and are not a shared constant. Frames to the spare address and a zero divide value exercise the decode and the limit arithmetic at their edges.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
package pwrseq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_WAKE = 2'd1,
    PS_RUN  = 2'd2
  } pstate_t;

  typedef enum logic [ADDR_W-1:0] {
    WA_PWR   = 2'd0,
    WA_RDIV  = 2'd1,
    WA_NDIV  = 2'd2,
    WA_SPARE = 2'd3
  } waddr_t;

  // Pin has priority: a low pin forces off regardless of the soft bit.
  function automatic logic pwr_request(input logic pin_en, input logic soft_pd);
    return pin_en & ~soft_pd;
  endfunction
endpackage

// File: rtl/pwrseq_serial_regs.sv
`timescale 1ns/1ps
module pwrseq_serial_regs
  import pwrseq_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int R_W     = 14,
  localparam int N_W    = FRAME_W - ADDR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_le_i,
  output logic           pd_bit_o,
  output logic           aux_bit_o,
  output logic [R_W-1:0] rdiv_o,
  output logic [N_W-1:0] ndiv_o
);
  logic [FRAME_W-1:0] shreg;
  logic               sck_q, le_q;
  logic               shift_evt, load_evt;
  waddr_t             frame_addr;

  assign shift_evt  = ser_clk_i & ~sck_q;
  assign load_evt   = ser_le_i & ~le_q;
  assign frame_addr = waddr_t'(shreg[ADDR_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      le_q  <= 1'b0;
      shreg <= '0;
    end else begin
      sck_q <= ser_clk_i;
      le_q  <= ser_le_i;
      if (shift_evt) shreg <= {shreg[FRAME_W-2:0], ser_dat_i};
    end
  end

  // Registers stay writable in every power state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_bit_o  <= 1'b0;
      aux_bit_o <= 1'b0;
      rdiv_o    <= R_W'(1);
      ndiv_o    <= N_W'(1);
    end else if (load_evt) begin
      unique case (frame_addr)
        WA_PWR: begin
          pd_bit_o  <= shreg[ADDR_W];
          aux_bit_o <= shreg[ADDR_W+1];
        end
        WA_RDIV:  rdiv_o <= shreg[ADDR_W +: R_W];
        WA_NDIV:  ndiv_o <= shreg[ADDR_W +: N_W];
        default: ;
      endcase
    end
  end

  a_r8_spare_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && frame_addr == WA_SPARE) |=>
      ($stable(pd_bit_o) && $stable(aux_bit_o) && $stable(rdiv_o) && $stable(ndiv_o)));

  a_r7_no_load_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(rdiv_o) && $stable(ndiv_o) && $stable(pd_bit_o)));
endmodule

// File: rtl/pwrseq_fsm.sv
`timescale 1ns/1ps
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en_i,
  input  logic pd_bit_i,
  input  logic aux_bit_i,
  output logic presc_en_o,
  output logic loop_drive_en_o,
  output logic ref_buf_en_o,
  output logic cnt_clr_o,
  output logic cnt_run_o
);
  pstate_t st, st_nx;
  logic    want_on;
  logic    wake_evt, release_evt;

  assign want_on = pwr_request(chip_en_i, pd_bit_i);

  always_comb begin
    unique case (st)
      PS_OFF:  st_nx = want_on ? PS_WAKE : PS_OFF;
      PS_WAKE: st_nx = want_on ? PS_RUN  : PS_OFF;
      PS_RUN:  st_nx = want_on ? PS_RUN  : PS_OFF;
      default: st_nx = PS_OFF;
    endcase
  end

  assign wake_evt    = (st == PS_OFF)  && (st_nx == PS_WAKE);
  assign release_evt = (st == PS_WAKE) && (st_nx == PS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PS_OFF;
    else        st <= st_nx;
  end

  assign presc_en_o      = (st != PS_OFF);
  assign loop_drive_en_o = (st == PS_RUN);
  assign cnt_run_o       = (st == PS_RUN);
  assign cnt_clr_o       = (st != PS_RUN);
  assign ref_buf_en_o    = (st != PS_OFF) | aux_bit_i;

  a_r1_drop_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    !want_on |=> (st == PS_OFF));

  a_r5_wake_precedes_drive: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (presc_en_o && !loop_drive_en_o));

  a_r5_release_drives: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> loop_drive_en_o);
endmodule

// File: rtl/pwrseq_divider.sv
`timescale 1ns/1ps
module pwrseq_divider #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         tc_o
);
  logic [W-1:0] cnt;
  logic         at_end;

  // Divide value 0 behaves as 1.
  function automatic logic [W-1:0] last_count(input logic [W-1:0] d);
    return (d == '0) ? '0 : d - W'(1);
  endfunction

  assign at_end = (cnt >= last_count(div_i));
  assign tc_o   = run_i & tick_i & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr_i)          cnt <= '0;
    else if (run_i && tick_i) cnt <= at_end ? '0 : cnt + W'(1);
  end

  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt == '0));

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> (cnt == '0));
endmodule

// File: rtl/pll_power_sequencer.sv
`timescale 1ns/1ps
module pll_power_sequencer
  import pwrseq_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int R_W     = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en_i,
  input  logic ser_clk_i,
  input  logic ser_dat_i,
  input  logic ser_le_i,
  input  logic ref_tick_i,
  input  logic vco_tick_i,
  output logic presc_en_o,
  output logic loop_drive_en_o,
  output logic ref_buf_en_o,
  output logic r_tc_o,
  output logic n_tc_o
);
  localparam int N_W = FRAME_W - ADDR_W;

  logic           pd_bit, aux_bit;
  logic [R_W-1:0] rdiv;
  logic [N_W-1:0] ndiv;
  logic           cnt_clr, cnt_run;

  pwrseq_serial_regs #(.FRAME_W(FRAME_W), .R_W(R_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i), .ser_le_i(ser_le_i),
    .pd_bit_o(pd_bit), .aux_bit_o(aux_bit), .rdiv_o(rdiv), .ndiv_o(ndiv)
  );

  pwrseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .chip_en_i(chip_en_i), .pd_bit_i(pd_bit), .aux_bit_i(aux_bit),
    .presc_en_o(presc_en_o), .loop_drive_en_o(loop_drive_en_o),
    .ref_buf_en_o(ref_buf_en_o), .cnt_clr_o(cnt_clr), .cnt_run_o(cnt_run)
  );

  pwrseq_divider #(.W(R_W)) u_rdiv (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .run_i(cnt_run),
    .tick_i(ref_tick_i), .div_i(rdiv), .tc_o(r_tc_o)
  );

  pwrseq_divider #(.W(N_W)) u_ndiv (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .run_i(cnt_run),
    .tick_i(vco_tick_i), .div_i(ndiv), .tc_o(n_tc_o)
  );

  a_r1_pin_low_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en_i |=> (!loop_drive_en_o && !presc_en_o));

  a_r2_keepalive_holds_ref: assert property (@(posedge clk) disable iff (!rst_n)
    aux_bit |-> ref_buf_en_o);

  a_r3_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_drive_en_o |-> (!r_tc_o && !n_tc_o));

  a_r5_drive_needs_prescaler: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_drive_en_o) |-> $past(presc_en_o));
endmodule

// File: tb/test_pll_power_sequencer.sv
`timescale 1ns/1ps
module test_pll_power_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, sck = 1'b0, sdat = 1'b0, sle = 1'b0;
  logic rtick = 1'b1, vtick = 1'b1;
  logic presc_en, drive_en, ref_buf_en, r_tc, n_tc;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pll_power_sequencer i_pll_power_sequencer (
    .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en),
    .ser_clk_i(sck), .ser_dat_i(sdat), .ser_le_i(sle),
    .ref_tick_i(rtick), .vco_tick_i(vtick),
    .presc_en_o(presc_en), .loop_drive_en_o(drive_en), .ref_buf_en_o(ref_buf_en),
    .r_tc_o(r_tc), .n_tc_o(n_tc)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [1:0] addr, input logic [21:0] data);
    logic [23:0] fr;
    fr = {data, addr};
    for (int b = 23; b >= 0; b--) begin
      sdat = fr[b]; sck = 1'b0; cyc(2);
      sck = 1'b1; cyc(2);
    end
    sck = 1'b0; cyc(2);
    sle = 1'b1; cyc(2);
    sle = 1'b0; cyc(2);
  endtask

  // Raises chip_en and returns first edge index of each terminal pulse.
  task automatic power_up_measure(output int ri, output int ni);
    ri = -1; ni = -1;
    chip_en = 1'b1;
    for (int i = 1; i <= 60; i++) begin
      cyc(1);
      if (r_tc && ri < 0) ri = i;
      if (n_tc && ni < 0) ni = i;
    end
  endtask

  task automatic t_reset;
    chk("R10 presc after reset", presc_en, 0);
    chk("R10 drive after reset", drive_en, 0);
    chk("R10 refbuf after reset", ref_buf_en, 0);
    chk("R10 tc after reset", r_tc | n_tc, 0);
  endtask

  task automatic t_program_off_and_powerup;
    int ri, ni;
    send_word(2'd1, 22'd5);
    send_word(2'd2, 22'd3);
    chk("R3 drive while off", drive_en, 0);
    chip_en = 1'b1; cyc(1);
    chk("R5 presc after one edge", presc_en, 1);
    chk("R5 drive low after one edge", drive_en, 0);
    cyc(1);
    chk("R5 drive after two edges", drive_en, 1);
    chip_en = 1'b0; cyc(3);
    power_up_measure(ri, ni);
    chk("R4 R7 first r_tc edge (R=5)", ri, 6);
    chk("R4 R7 first n_tc edge (N=3)", ni, 4);
  endtask

  task automatic t_pin_override;
    int seen = 0;
    chip_en = 1'b0; cyc(1);
    chk("R1 pin low drive", drive_en, 0);
    chk("R1 pin low presc", presc_en, 0);
    for (int i = 0; i < 12; i++) begin cyc(1); seen += (r_tc | n_tc); end
    chk("R3 no tc while off", seen, 0);
  endtask

  task automatic t_soft_pd;
    chip_en = 1'b1; cyc(5);
    chk("R1 running before soft pd", drive_en, 1);
    send_word(2'd0, 22'b01);
    cyc(2);
    chk("R1 soft pd drive", drive_en, 0);
    chk("R1 soft pd presc", presc_en, 0);
    chk("R2 refbuf off without keep-alive", ref_buf_en, 0);
  endtask

  task automatic t_keepalive;
    send_word(2'd0, 22'b11);
    cyc(1);
    chk("R2 keep-alive refbuf with pd", ref_buf_en, 1);
    chk("R2 keep-alive loop still off", drive_en, 0);
    chip_en = 1'b0; cyc(2);
    chk("R2 keep-alive refbuf with pin low", ref_buf_en, 1);
    send_word(2'd0, 22'b00);
    cyc(1);
    chk("R2 refbuf low after clearing", ref_buf_en, 0);
  endtask

  task automatic t_realign;
    int ri, ni, mism;
    send_word(2'd1, 22'd5);
    send_word(2'd2, 22'd5);
    chip_en = 1'b1; cyc(9);
    chip_en = 1'b0; cyc(3);
    power_up_measure(ri, ni);
    chk("R6 first r_tc after mid-count stop", ri, 6);
    chk("R6 first n_tc after mid-count stop", ni, 6);
    mism = 0;
    for (int i = 0; i < 30; i++) begin cyc(1); if (r_tc != n_tc) mism++; end
    chk("R6 pulses coincide", mism, 0);
  endtask

  task automatic t_spare;
    int last, gap, bad_drive;
    send_word(2'd3, 22'h3FFFFF);
    chk("R8 spare keeps power", drive_en, 1);
    last = -1; gap = -1; bad_drive = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (!drive_en) bad_drive++;
      if (r_tc) begin
        if (last >= 0 && gap < 0) gap = i - last;
        last = i;
      end
    end
    chk("R8 spare drive stays on", bad_drive, 0);
    chk("R8 spare keeps R period", gap, 5);
  endtask

  task automatic t_div_zero;
    int hits = 0;
    send_word(2'd1, 22'd0);
    cyc(3);
    for (int i = 0; i < 6; i++) begin cyc(1); hits += r_tc; end
    chk("R9 zero divide pulses each tick", hits, 6);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_program_off_and_powerup();
    t_pin_override();
    t_soft_pd();
    t_keepalive();
    t_realign();
    t_spare();
    t_div_zero();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule